// File: doc/BRIEF.md
# Packed-Lane SIMD Arithmetic Unit

This unit takes two 64-bit register operands and treats each as a vector of equal-width elements. The element width is chosen per operation: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. One 64-bit adder is split at run time into independent lanes by cutting its carry at the chosen boundaries. Each lane can add or subtract with wraparound, with unsigned clamping or with signed clamping.

The unit also forms signed lane products and keeps either the low or the high half of each one. It has a fused operation that adds pairs of signed 16-bit products into two 32-bit results, and it has 64-bit bitwise AND and OR. A core issues one operation per cycle with `in_valid_i`. The result appears on `res_o` one clock later together with `out_valid_o`. An illegal combination gives a zero result and raises `err_o`.

Top module: `simd_alu`

## Requirements
- R1: Opcode 0 (wrapping add) adds each lane modulo 2^w. The lane code `lsz_i` is 0 for 8-bit lanes, 1 for 16-bit lanes and 2 for 32-bit lanes. Lane k occupies bits [w*k+w-1 : w*k]. No carry crosses from one lane into the next.
- R2: Opcode 3 (wrapping subtract) gives a-b modulo 2^w in each lane. No borrow crosses a lane boundary.
- R3: Opcodes 1 and 4 are add and subtract with unsigned clamping. A lane result above 2^w-1 becomes all ones. A lane result below 0 becomes 0.
- R4: Opcodes 2 and 5 are add and subtract with signed clamping. A lane result is clamped to the range -2^(w-1) to 2^(w-1)-1.
- R5: Opcode 6 gives the low w bits of the signed product of each lane pair, for 16-bit or 32-bit lanes.
- R6: Opcode 7 gives the high w bits of the signed 2w-bit product of each lane pair, for 16-bit or 32-bit lanes.
- R7: Opcode 8 ignores `lsz_i` and forms the four signed 16-bit lane products. Bits [31:0] hold product0+product1 and bits [63:32] hold product2+product3, each summed modulo 2^32.
- R8: Opcode 9 gives a AND b and opcode 10 gives a OR b over all 64 bits. Both ignore `lsz_i`.
- R9: The following cases give `res_o`=0 and `err_o`=1: opcodes 6 or 7 with `lsz_i`=0, any of opcodes 0 to 7 with `lsz_i`=3, and any opcode from 11 to 15. Every other case gives `err_o`=0.
- R10: After reset `res_o`, `err_o` and `out_valid_o` are all 0. `out_valid_o` equals `in_valid_i` from one cycle earlier. While `in_valid_i` is low, `res_o` and `err_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Issues an operation this cycle |
| op_i | input | 4 | Opcode |
| lsz_i | input | 2 | Lane width code |
| a_i | input | 64 | Packed operand A |
| b_i | input | 64 | Packed operand B |
| out_valid_o | output | 1 | Result valid, one cycle after issue |
| res_o | output | 64 | Packed result |
| err_o | output | 1 | Illegal combination flag |

## Verification
The hardest case to reach is a carry or overflow at the top of a lane that must not reach the next lane. Random operands seldom produce it in every lane at once, and seldom at every lane width. The stimulus therefore uses directed operands: all-ones plus one, zero minus one, and maximum and minimum signed values placed in every lane. Each of these patterns is replayed with all three lane codes. Random traffic with idle gaps between operations then covers the hold behaviour and the mix of opcodes.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADDUS = 4'd1, OP_ADDSS = 4'd2,
    OP_SUB = 4'd3, OP_SUBUS = 4'd4, OP_SUBSS = 4'd5,
    OP_MULLO = 4'd6, OP_MULHI = 4'd7, OP_MADD = 4'd8,
    OP_AND = 4'd9, OP_OR = 4'd10
  } op_e;

  typedef enum logic [1:0] {LS_8 = 2'd0, LS_16 = 2'd1, LS_32 = 2'd2, LS_BAD = 2'd3} lsz_e;

  typedef enum logic [1:0] {SAT_NONE = 2'd0, SAT_U = 2'd1, SAT_S = 2'd2} sat_e;
endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  sat_e              sat_i,
  input  logic [1:0]        lsz_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] bx, raw;
  logic [NB-1:0]     cout, ovf_u, ovf_s;
  int                lmask;

  always_comb begin
    lmask = (lsz_i == 2'd0) ? 0 : (lsz_i == 2'd1) ? 1 : 3;
  end

  // segmented ripple: carry-in forced to sub_i at each lane bottom
  always_comb begin
    logic       c, cin;
    logic [8:0] s9;
    bx = sub_i ? ~b_i : b_i;
    c  = 1'b0;
    for (int i = 0; i < NB; i++) begin
      cin  = ((i & lmask) == 0) ? sub_i : c;
      s9   = {1'b0, a_i[8*i +: 8]} + {1'b0, bx[8*i +: 8]} + {8'd0, cin};
      raw[8*i +: 8] = s9[7:0];
      c        = s9[8];
      cout[i]  = s9[8];
      ovf_u[i] = s9[8] ^ sub_i;
      ovf_s[i] = (a_i[8*i+7] == bx[8*i+7]) && (s9[7] != a_i[8*i+7]);
    end
  end

  always_comb begin
    int   t;
    logic neg;
    for (int i = 0; i < NB; i++) begin
      t   = i | lmask;
      neg = a_i[8*t+7];
      sum_o[8*i +: 8] = raw[8*i +: 8];
      if (sat_i == SAT_U && ovf_u[t]) begin
        sum_o[8*i +: 8] = sub_i ? 8'h00 : 8'hFF;
      end else if (sat_i == SAT_S && ovf_s[t]) begin
        if (i == t) sum_o[8*i +: 8] = neg ? 8'h80 : 8'h7F;
        else        sum_o[8*i +: 8] = neg ? 8'h00 : 8'hFF;
      end
    end
  end

  logic unused_cout;
  assign unused_cout = ^cout;
endmodule

// File: rtl/simd_mul.sv
module simd_mul #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]            a_i,
  input  logic [DATA_W-1:0]            b_i,
  input  logic                         hi_i,
  input  logic [1:0]                   lsz_i,
  output logic [DATA_W/16-1:0][31:0]   p16_o,
  output logic [DATA_W-1:0]            res_o
);
  localparam int NH = DATA_W / 16;
  localparam int NW = DATA_W / 32;

  logic [DATA_W-1:0] r16, r32;

  for (genvar g = 0; g < NH; g++) begin : g_h
    logic signed [31:0] ea, eb, p;
    assign ea = {{16{a_i[16*g+15]}}, a_i[16*g +: 16]};
    assign eb = {{16{b_i[16*g+15]}}, b_i[16*g +: 16]};
    assign p  = ea * eb;
    assign p16_o[g] = p;
    assign r16[16*g +: 16] = hi_i ? p[31:16] : p[15:0];
  end

  for (genvar g = 0; g < NW; g++) begin : g_w
    logic signed [63:0] ea, eb, p;
    assign ea = {{32{a_i[32*g+31]}}, a_i[32*g +: 32]};
    assign eb = {{32{b_i[32*g+31]}}, b_i[32*g +: 32]};
    assign p  = ea * eb;
    assign r32[32*g +: 32] = hi_i ? p[63:32] : p[31:0];
  end

  assign res_o = (lsz_i == 2'd2) ? r32 : r16;
endmodule

// File: rtl/simd_madd.sv
module simd_madd #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W/16-1:0][31:0] p16_i,
  output logic [DATA_W-1:0]          res_o
);
  localparam int NP = DATA_W / 32;

  for (genvar k = 0; k < NP; k++) begin : g_pair
    assign res_o[32*k +: 32] = p16_i[2*k] + p16_i[2*k+1];
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        lsz_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic              err_o
);
  localparam int NH = DATA_W / 16;

  logic [DATA_W-1:0]   as_res, mul_res, madd_res, res_c;
  logic [NH-1:0][31:0] p16;
  logic                sub_c, err_c;
  sat_e                sat_c;

  always_comb begin
    sub_c = (op_i == OP_SUB) || (op_i == OP_SUBUS) || (op_i == OP_SUBSS);
    case (op_i)
      OP_ADDUS, OP_SUBUS: sat_c = SAT_U;
      OP_ADDSS, OP_SUBSS: sat_c = SAT_S;
      default:            sat_c = SAT_NONE;
    endcase
  end

  simd_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_c), .sat_i(sat_c), .lsz_i(lsz_i), .sum_o(as_res)
  );

  simd_mul #(.DATA_W(DATA_W)) u_mul (
    .a_i(a_i), .b_i(b_i), .hi_i(op_i == OP_MULHI), .lsz_i(lsz_i),
    .p16_o(p16), .res_o(mul_res)
  );

  simd_madd #(.DATA_W(DATA_W)) u_madd (.p16_i(p16), .res_o(madd_res));

  always_comb begin
    res_c = '0;
    err_c = 1'b0;
    case (op_i)
      OP_ADD, OP_ADDUS, OP_ADDSS, OP_SUB, OP_SUBUS, OP_SUBSS: begin
        if (lsz_i == LS_BAD) err_c = 1'b1;
        else                 res_c = as_res;
      end
      OP_MULLO, OP_MULHI: begin
        if (lsz_i == LS_8 || lsz_i == LS_BAD) err_c = 1'b1;
        else                                  res_c = mul_res;
      end
      OP_MADD: res_c = madd_res;
      OP_AND:  res_c = a_i & b_i;
      OP_OR:   res_c = a_i | b_i;
      default: err_c = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      res_o       <= '0;
      err_o       <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        res_o <= res_c;
        err_o <= err_c;
      end
    end
  end

  a_r10_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r10_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(res_o) && $stable(err_o)));
  a_r9_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (res_o == '0));
  a_r9_mul_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == OP_MULLO && lsz_i == LS_8) |=> err_o);
  a_r8_and: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == OP_AND) |=> (!err_o && res_o == $past(a_i & b_i)));
endmodule

// File: tb/simd_alu_tb_top.sv
`timescale 1ns/1ps
module simd_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  lsz = '0;
  logic [63:0] a = '0, b = '0;
  logic        out_valid, err;
  logic [63:0] res;

  int checks = 0, errors = 0;
  logic        exp_v = 1'b0, exp_err = 1'b0;
  logic [63:0] exp_res = '0;
  string       exp_tag = "R10";

  always #2.5 clk = ~clk;

  simd_alu dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .op_i(op), .lsz_i(lsz),
    .a_i(a), .b_i(b), .out_valid_o(out_valid), .res_o(res), .err_o(err)
  );

  function automatic logic [64:0] model(logic [63:0] x, logic [63:0] y, logic [3:0] o, logic [1:0] s);
    logic [63:0] r = '0, m, ux, uy;
    longint sx, sy, v, lo, hi;
    int w, n, mode;
    bit sb;
    if (o == 4'd9) return {1'b0, x & y};
    if (o == 4'd10) return {1'b0, x | y};
    if (o == 4'd8) begin
      for (int k = 0; k < 2; k++) begin
        v = 0;
        for (int j = 0; j < 2; j++) begin
          sx = longint'($signed(x[32*k+16*j +: 16]));
          sy = longint'($signed(y[32*k+16*j +: 16]));
          v += sx * sy;
        end
        r[32*k +: 32] = v[31:0];
      end
      return {1'b0, r};
    end
    if (o > 4'd10) return {1'b1, 64'd0};
    if (s == 2'd3) return {1'b1, 64'd0};
    if (o >= 4'd6 && s == 2'd0) return {1'b1, 64'd0};
    w = 8 << s; n = 64 / w;
    m = (64'd1 << w) - 64'd1;
    sb = (o >= 4'd3 && o <= 4'd5);
    mode = o % 3;
    lo = -(longint'(1) << (w - 1)); hi = (longint'(1) << (w - 1)) - 1;
    for (int i = 0; i < n; i++) begin
      ux = (x >> (w * i)) & m;
      uy = (y >> (w * i)) & m;
      sx = longint'(ux); if (ux[w-1]) sx -= longint'(64'd1 << w);
      sy = longint'(uy); if (uy[w-1]) sy -= longint'(64'd1 << w);
      if (o == 4'd6)      v = sx * sy;
      else if (o == 4'd7) v = (sx * sy) >>> w;
      else if (mode == 2) begin
        v = sb ? sx - sy : sx + sy;
        if (v > hi) v = hi;
        if (v < lo) v = lo;
      end else begin
        v = sb ? longint'(ux) - longint'(uy) : longint'(ux) + longint'(uy);
        if (mode == 1) begin
          if (v < 0) v = 0;
          if (v > longint'(m)) v = longint'(m);
        end
      end
      r |= (64'(v) & m) << (w * i);
    end
    return {1'b0, r};
  endfunction

  function automatic string tag_of(logic [3:0] o, logic e);
    if (e) return "R9";
    case (o)
      4'd0: return "R1";
      4'd3: return "R2";
      4'd1, 4'd4: return "R3";
      4'd2, 4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_outputs();
    checks++;
    if (out_valid !== exp_v) begin
      errors++;
      $display("FAIL R10 out_valid actual %0b expected %0b", out_valid, exp_v);
    end
    checks++;
    if (res !== exp_res || err !== exp_err) begin
      errors++;
      $display("FAIL %s res/err actual %h/%0b expected %h/%0b", exp_tag, res, err, exp_res, exp_err);
    end
  endtask

  // one cycle: check what the last posedge produced, then drive the next input
  task automatic step(logic v, logic [3:0] o, logic [1:0] s, logic [63:0] x, logic [63:0] y);
    logic [64:0] m;
    @(negedge clk);
    check_outputs();
    in_valid = v; op = o; lsz = s; a = x; b = y;
    exp_v = v;
    if (v) begin
      m = model(x, y, o, s);
      exp_err = m[64]; exp_res = m[63:0];
      exp_tag = tag_of(o, m[64]);
    end else begin
      exp_tag = "R10";
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_outputs();  // R10 reset state
    rst_ni = 1'b1;
    for (int s = 0; s < 3; s++) begin
      // R1 carry at every lane top; R2 borrow at every lane bottom
      step(1, 4'd0, 2'(s), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
      step(1, 4'd0, 2'(s), 64'h80FF_7FFF_FF80_00FF, 64'h8001_0001_0180_0001);
      step(1, 4'd3, 2'(s), 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101);
      // R3 unsigned clamp
      step(1, 4'd1, 2'(s), 64'hFFF0_8000_7FFF_0001, 64'h0020_8000_0001_0001);
      step(1, 4'd4, 2'(s), 64'h0010_8000_0001_FFFF, 64'h0020_7FFF_0002_0001);
      // R4 signed clamp
      step(1, 4'd2, 2'(s), 64'h7F7F_7FFF_8080_8000, 64'h0101_0001_FFFF_FFFF);
      step(1, 4'd5, 2'(s), 64'h8080_8000_7F7F_7FFF, 64'h0101_0001_FFFF_FFFF);
      // R5 R6 R9 multiply halves, byte lanes illegal
      step(1, 4'd6, 2'(s), 64'hFFFF_8000_7FFF_0003, 64'h8000_8000_7FFF_FFFE);
      step(1, 4'd7, 2'(s), 64'hFFFF_8000_7FFF_0003, 64'h8000_8000_7FFF_FFFE);
    end
    step(1, 4'd8, 2'd0, 64'h8000_8000_7FFF_FFFF, 64'h8000_8000_7FFF_0002); // R7
    step(1, 4'd9, 2'd3, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FF00_1234_FFFF); // R8
    step(1, 4'd10, 2'd1, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FF00_1234_FFFF);
    step(1, 4'd0, 2'd3, 64'h1, 64'h1);   // R9 bad lane code
    step(1, 4'd15, 2'd1, 64'h1, 64'h1);  // R9 bad opcode
    step(0, 4'd9, 2'd0, 64'h5, 64'h3);   // R10 hold
    step(0, 4'd0, 2'd0, 64'h7, 64'h3);
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 4) != 0, 4'($urandom % 12), 2'($urandom % 4),
           {$urandom, $urandom}, {$urandom, $urandom});
    end
    step(0, 4'd0, 2'd0, 64'h0, 64'h0);
    @(negedge clk);
    check_outputs();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule